// File: doc/BRIEF.md
# Multichannel Scan Sequencer with Event Detection

The sequencer walks a bank of up to 16 channel slots and, for every slot that is switched on, runs an acquisition window followed by a conversion request to an external converter. A slot may accumulate a power-of-two number of conversions and report their truncated mean. Every raw sample can be tested for saturation, and every final result can be tested against a pair of limits. Each final result leaves on a result port tagged with its slot number.

One pulse on `scan_start` launches a burst of one or more complete scans. When the last scan of the burst finishes, an end-of-scan event is posted. The three event kinds are end-of-scan, saturation and range. Each has a sticky status bit and a mask bit, and the masked bits are ORed into a single interrupt line. Configuration arrives on plain input ports.

The control is one state machine with these states:
- `ST_IDLE`: waits for a start.
- `ST_SEEK`: picks the next enabled slot, or closes the scan.
- `ST_ACQ`: counts the acquisition window.
- `ST_CONV`: issues the one-cycle conversion request.
- `ST_WAIT`: waits for the converter's done.
- `ST_EMIT`: presents the result.

Its transitions are:
- IDLE→SEEK on start.
- SEEK→ACQ when a slot is found.
- SEEK→SEEK when a scan ends and more scans remain.
- SEEK→IDLE when the last scan ends.
- ACQ→CONV when the window expires.
- CONV→WAIT always.
- WAIT→ACQ on done while samples remain.
- WAIT→EMIT on done for the last sample.
- EMIT→SEEK always.

Top module: `scan_sequencer`

## Requirements
- R1: A scan produces exactly one result per enabled slot of `cfg_ch_en`, in strictly ascending slot order, with `res_chan` equal to the slot number. Disabled slots produce nothing.
- R2: Slot c uses acquisition field `cfg_acq_sel[2c+1:2c]`. Field k is `cfg_acq_time[10k+9:10k]` and holds N converter clocks, where a value of 0 counts as 1. The first `conv_start` of a scan is high in the (N+2)-th cycle after the edge that accepts `scan_start`: one seek cycle, N acquisition cycles, then the request.
- R3: When `cfg_avg_en[c]` is 1, slot c performs 2^k conversions (k = `cfg_avg_log2`, 0..7), each with its own acquisition window. It reports (sum of samples) >> k. When `cfg_avg_en[c]` is 0, it performs one conversion and reports it unchanged, whatever k is.
- R4: A raw sample equal to 0 or 4095 on a slot with `cfg_sat_en[c]`=1 sets status bit 1, even when the averaged result is not saturated. With the enable at 0, the bit is left unchanged.
- R5: On a slot with `cfg_rng_en[c]`=1, the final result v sets status bit 2 when the `cfg_rng_mode` condition holds: 0 means v < low, 1 means low ≤ v ≤ high, 2 means v > high, 3 means v < low or v > high.
- R6: Status bit 0 (end-of-scan) is set once, after `cfg_scan_cnt` back-to-back scans launched by one start; a count of 0 or 1 means a single scan. It stays 0 while earlier scans of the burst complete.
- R7: `scan_start` is ignored while `busy` is 1.
- R8: Status bits are sticky and are cleared by writing 1 to the matching `evt_clear` bit; a set in the same cycle wins. `irq` is 1 exactly when some status bit and its `evt_mask` bit are both 1.
- R9: After reset, `busy`, `conv_start`, `res_valid`, `evt_status` and `irq` are all 0.
- R10: `conv_start` is high for one cycle only, and no new request is issued before `conv_done` answers the previous one.
- R11: A start with no slot enabled finishes the scan burst at once: end-of-scan is set and no result or conversion request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ch_en | input | NUM_CH | Slot enables |
| cfg_acq_sel | input | 2*NUM_CH | Per-slot acquisition field select |
| cfg_acq_time | input | 4*ACQ_W | Four shared acquisition lengths |
| cfg_avg_en | input | NUM_CH | Per-slot averaging enable |
| cfg_avg_log2 | input | AVG_LOG_W | log2 of the averaging count |
| cfg_sat_en | input | NUM_CH | Per-slot saturation detect enable |
| cfg_rng_en | input | NUM_CH | Per-slot range detect enable |
| cfg_rng_mode | input | 2 | Range condition code |
| cfg_rng_low | input | RES_W | Lower limit |
| cfg_rng_high | input | RES_W | Upper limit |
| cfg_scan_cnt | input | SCNT_W | Scans per start |
| scan_start | input | 1 | Start pulse |
| conv_start | output | 1 | Conversion request |
| conv_done | input | 1 | Conversion finished, data valid |
| conv_data | input | RES_W | Raw sample |
| res_valid | output | 1 | Result valid strobe |
| res_chan | output | CH_W | Slot of the result |
| res_data | output | RES_W | Final result |
| busy | output | 1 | Scan burst in progress |
| evt_clear | input | 3 | Write-1 clear of status bits |
| evt_mask | input | 3 | Interrupt mask |
| evt_status | output | 3 | Sticky status: bit0 end-of-scan, bit1 saturation, bit2 range |
| irq | output | 1 | Masked interrupt |

## Verification
Several properties are checked on every cycle:
- A result only ever carries an enabled slot.
- Slot tags rise within a scan.
- A conversion request never lasts two cycles.
- A request is never issued while one is outstanding.
- Status bits never drop without a clear.
- The interrupt never rises with empty status.

Other behaviours depend on configured values and arithmetic and can only be shown by the bench scenarios:
- The exact acquisition latency for each field.
- The averaged values and their sample counts.
- Saturation detected on an unsaturated mean.
- Each range code.
- Deferral of end-of-scan across a scan burst.
- Rejection of a restart during a scan.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEEK,
        ST_ACQ,
        ST_CONV,
        ST_WAIT,
        ST_EMIT
    } seq_state_t;

    typedef enum logic [1:0] {
        RNG_BELOW   = 2'd0,
        RNG_INSIDE  = 2'd1,
        RNG_ABOVE   = 2'd2,
        RNG_OUTSIDE = 2'd3
    } rng_mode_t;

    localparam int ACQ_FIELDS = 4;
    localparam int ACQ_SEL_W  = $clog2(ACQ_FIELDS);

    localparam int EVT_N   = 3;
    localparam int EVT_EOS = 0;
    localparam int EVT_SAT = 1;
    localparam int EVT_RNG = 2;

endpackage

// File: rtl/scan_chan_pick.sv
module scan_chan_pick #(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4,
    parameter int PTR_W  = 5
) (
    input  logic [NUM_CH-1:0] en,
    input  logic [PTR_W-1:0]  from,
    output logic              found,
    output logic [CH_W-1:0]   idx
);
    // lowest enabled slot at or above the pointer
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (en[i] && (PTR_W'(i) >= from)) begin
                found = 1'b1;
                idx   = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/scan_limit_cmp.sv
module scan_limit_cmp
    import scan_seq_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0] value,
    input  logic [RES_W-1:0] low,
    input  logic [RES_W-1:0] high,
    input  rng_mode_t        mode,
    output logic             hit
);
    logic under, over;

    always_comb begin
        under = value < low;
        over  = value > high;
        unique case (mode)
            RNG_BELOW:   hit = under;
            RNG_INSIDE:  hit = !under && !over;
            RNG_ABOVE:   hit = over;
            RNG_OUTSIDE: hit = under || over;
            default:     hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/scan_evt_reg.sv
module scan_evt_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | set;
    end

    always_comb irq = |(status & mask);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((($past(status) & ~$past(clr)) & ~status) == '0));

    // R8
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int RES_W     = 12,
    parameter int ACQ_W     = 10,
    parameter int AVG_LOG_W = 3,
    parameter int SCNT_W    = 4,
    localparam int CH_W     = $clog2(NUM_CH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           cfg_ch_en,
    input  logic [NUM_CH*ACQ_SEL_W-1:0] cfg_acq_sel,
    input  logic [ACQ_FIELDS*ACQ_W-1:0] cfg_acq_time,
    input  logic [NUM_CH-1:0]           cfg_avg_en,
    input  logic [AVG_LOG_W-1:0]        cfg_avg_log2,
    input  logic [NUM_CH-1:0]           cfg_sat_en,
    input  logic [NUM_CH-1:0]           cfg_rng_en,
    input  logic [1:0]                  cfg_rng_mode,
    input  logic [RES_W-1:0]            cfg_rng_low,
    input  logic [RES_W-1:0]            cfg_rng_high,
    input  logic [SCNT_W-1:0]           cfg_scan_cnt,
    input  logic                        scan_start,
    output logic                        conv_start,
    input  logic                        conv_done,
    input  logic [RES_W-1:0]            conv_data,
    output logic                        res_valid,
    output logic [CH_W-1:0]             res_chan,
    output logic [RES_W-1:0]            res_data,
    output logic                        busy,
    input  logic [EVT_N-1:0]            evt_clear,
    input  logic [EVT_N-1:0]            evt_mask,
    output logic [EVT_N-1:0]            evt_status,
    output logic                        irq
);
    localparam int PTR_W   = CH_W + 1;
    localparam int AVG_MAX = (1 << AVG_LOG_W) - 1;
    localparam int SUM_W   = RES_W + AVG_MAX;
    localparam int SMP_W   = AVG_MAX + 1;
    localparam logic [RES_W-1:0] RES_TOP = {RES_W{1'b1}};

    seq_state_t state, nxt;

    logic [PTR_W-1:0]     ptr;
    logic [CH_W-1:0]      cur_ch;
    logic [ACQ_W-1:0]     acq_cnt, acq_rel;
    logic [SMP_W-1:0]     smp_left;
    logic [SUM_W-1:0]     sum;
    logic [SCNT_W-1:0]    scans_left;
    logic [AVG_LOG_W-1:0] shift_q;

    logic                 pick_found;
    logic [CH_W-1:0]      pick_idx;
    logic [ACQ_W-1:0]     pick_acq, eff_acq;
    logic [AVG_LOG_W-1:0] pick_shift;
    logic [SUM_W-1:0]     shifted;
    logic                 rng_hit;
    logic [EVT_N-1:0]     evt_set;
    logic                 last_scan;

    // configuration fan-out
    logic [ACQ_W-1:0]     acq_fld [ACQ_FIELDS];
    logic [ACQ_SEL_W-1:0] ch_sel  [NUM_CH];

    for (genvar f = 0; f < ACQ_FIELDS; f++) begin : g_acq_fld
        assign acq_fld[f] = cfg_acq_time[f*ACQ_W +: ACQ_W];
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_sel
        assign ch_sel[c] = cfg_acq_sel[c*ACQ_SEL_W +: ACQ_SEL_W];
    end

    scan_chan_pick #(
        .NUM_CH(NUM_CH),
        .CH_W  (CH_W),
        .PTR_W (PTR_W)
    ) u_pick (
        .en   (cfg_ch_en),
        .from (ptr),
        .found(pick_found),
        .idx  (pick_idx)
    );

    always_comb begin
        pick_acq   = acq_fld[ch_sel[pick_idx]];
        eff_acq    = (pick_acq == '0) ? ACQ_W'(1) : pick_acq;
        pick_shift = cfg_avg_en[pick_idx] ? cfg_avg_log2 : '0;
        shifted    = sum >> shift_q;
        last_scan  = scans_left <= SCNT_W'(1);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (scan_start) nxt = ST_SEEK;
            ST_SEEK: begin
                if (pick_found)     nxt = ST_ACQ;
                else if (last_scan) nxt = ST_IDLE;
                else                nxt = ST_SEEK;
            end
            ST_ACQ:  if (acq_cnt == ACQ_W'(1)) nxt = ST_CONV;
            ST_CONV: nxt = ST_WAIT;
            ST_WAIT: if (conv_done) nxt = (smp_left == SMP_W'(1)) ? ST_EMIT : ST_ACQ;
            ST_EMIT: nxt = ST_SEEK;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        conv_start = (state == ST_CONV);
        res_valid  = (state == ST_EMIT);
        busy       = (state != ST_IDLE);
        res_chan   = cur_ch;
        res_data   = shifted[RES_W-1:0];
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            cur_ch     <= '0;
            acq_cnt    <= '0;
            acq_rel    <= '0;
            smp_left   <= '0;
            sum        <= '0;
            scans_left <= '0;
            shift_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (scan_start) begin
                    ptr        <= '0;
                    scans_left <= (cfg_scan_cnt == '0) ? SCNT_W'(1) : cfg_scan_cnt;
                end
                ST_SEEK: begin
                    if (pick_found) begin
                        cur_ch   <= pick_idx;
                        acq_cnt  <= eff_acq;
                        acq_rel  <= eff_acq;
                        smp_left <= SMP_W'(1) << pick_shift;
                        shift_q  <= pick_shift;
                        sum      <= '0;
                    end else if (!last_scan) begin
                        scans_left <= scans_left - SCNT_W'(1);
                        ptr        <= '0;
                    end
                end
                ST_ACQ:  acq_cnt <= acq_cnt - ACQ_W'(1);
                ST_CONV: ;
                ST_WAIT: if (conv_done) begin
                    sum      <= sum + SUM_W'(conv_data);
                    smp_left <= smp_left - SMP_W'(1);
                    acq_cnt  <= acq_rel;
                end
                ST_EMIT: ptr <= PTR_W'(cur_ch) + PTR_W'(1);
                default: ;
            endcase
        end
    end

    scan_limit_cmp #(.RES_W(RES_W)) u_cmp (
        .value(res_data),
        .low  (cfg_rng_low),
        .high (cfg_rng_high),
        .mode (rng_mode_t'(cfg_rng_mode)),
        .hit  (rng_hit)
    );

    always_comb begin
        evt_set          = '0;
        evt_set[EVT_EOS] = (state == ST_SEEK) && !pick_found && last_scan;
        evt_set[EVT_SAT] = (state == ST_WAIT) && conv_done && cfg_sat_en[cur_ch]
                           && ((conv_data == '0) || (conv_data == RES_TOP));
        evt_set[EVT_RNG] = (state == ST_EMIT) && cfg_rng_en[cur_ch] && rng_hit;
    end

    scan_evt_reg #(.N(EVT_N)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt_set),
        .clr   (evt_clear),
        .mask  (evt_mask),
        .status(evt_status),
        .irq   (irq)
    );

    // ordering checker state
    logic            chk_seen;
    logic [CH_W-1:0] chk_last;
    logic            chk_pend;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_seen <= 1'b0;
            chk_last <= '0;
            chk_pend <= 1'b0;
        end else begin
            if (res_valid) begin
                chk_seen <= 1'b1;
                chk_last <= res_chan;
            end else if ((state == ST_SEEK) && !pick_found) begin
                chk_seen <= 1'b0;
            end
            if (conv_start)     chk_pend <= 1'b1;
            else if (conv_done) chk_pend <= 1'b0;
        end
    end

    // R1
    res_chan_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> cfg_ch_en[res_chan]);

    // R1
    ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && chk_seen) |-> (res_chan > chk_last));

    // R10
    conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R10
    conv_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !chk_pend);
endmodule

// File: tb/scan_sequencer_bench.sv
module scan_sequencer_bench;
    localparam int NUM_CH = 16;
    localparam int RES_W  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [15:0] cfg_ch_en = '0, cfg_avg_en = '0, cfg_sat_en = '0, cfg_rng_en = '0;
    logic [31:0] cfg_acq_sel = '0;
    logic [39:0] cfg_acq_time = {10'd5, 10'd0, 10'd1, 10'd3};
    logic [2:0]  cfg_avg_log2 = '0;
    logic [1:0]  cfg_rng_mode = '0;
    logic [11:0] cfg_rng_low = 12'd1000, cfg_rng_high = 12'd2000;
    logic [3:0]  cfg_scan_cnt = '0;
    logic        scan_start = 1'b0, conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic [2:0]  evt_clear = '0, evt_mask = '0;
    logic        conv_start, res_valid, busy, irq;
    logic [3:0]  res_chan;
    logic [11:0] res_data;
    logic [2:0]  evt_status;

    scan_sequencer u_scan_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_ch_en(cfg_ch_en), .cfg_acq_sel(cfg_acq_sel),
        .cfg_acq_time(cfg_acq_time), .cfg_avg_en(cfg_avg_en), .cfg_avg_log2(cfg_avg_log2),
        .cfg_sat_en(cfg_sat_en), .cfg_rng_en(cfg_rng_en), .cfg_rng_mode(cfg_rng_mode),
        .cfg_rng_low(cfg_rng_low), .cfg_rng_high(cfg_rng_high), .cfg_scan_cnt(cfg_scan_cnt),
        .scan_start(scan_start), .conv_start(conv_start), .conv_done(conv_done),
        .conv_data(conv_data), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .busy(busy), .evt_clear(evt_clear), .evt_mask(evt_mask),
        .evt_status(evt_status), .irq(irq)
    );

    int errors = 0, checks = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // converter model: sample k of a run is base + k*step
    logic [11:0] conv_base = '0, conv_step = '0;
    int conv_k = 0, n_conv = 0, conv_viol = 0;
    bit pend = 1'b0, prev_cs = 1'b0;

    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                repeat (2) @(negedge clk);
                conv_data = conv_base + conv_step * 12'(conv_k);
                conv_k++;
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    // request monitor (R10)
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                n_conv++;
                if (prev_cs || pend) conv_viol++;
                pend = 1'b1;
            end
            if (conv_done) pend = 1'b0;
            prev_cs = conv_start;
        end
    end

    int   n_res, first_lat;
    int   r_ch [16];
    int   r_val[16];
    bit   r_eos[16];

    task automatic run_scan(input int restart_at);
        int cyc;
        n_res = 0; first_lat = 0; conv_k = 0; n_conv = 0;
        @(negedge clk); scan_start = 1'b1;
        @(negedge clk); scan_start = 1'b0;
        cyc = 1;
        while (1) begin
            if (conv_start && first_lat == 0) first_lat = cyc;
            if (res_valid && n_res < 16) begin
                r_ch[n_res] = int'(res_chan);
                r_val[n_res] = int'(res_data);
                r_eos[n_res] = evt_status[0];
                n_res++;
            end
            if (!busy || cyc > 3000) break;
            @(negedge clk);
            cyc++;
            scan_start = (cyc == restart_at);
        end
        scan_start = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk); evt_clear = 3'b111;
        @(negedge clk); evt_clear = 3'b000;
    endtask

    typedef struct packed {
        logic [3:0]  ch;
        logic [1:0]  sel;
        logic [2:0]  lg;
        logic [11:0] base;
        logic [11:0] step;
        logic [11:0] exp_val;
        logic [7:0]  lat;
    } vec_t;

    // fields: field0=3 field1=1 field2=0(->1) field3=5
    localparam vec_t VECS[4] = '{
        '{4'd3,  2'd0, 3'd0, 12'd1234, 12'd0, 12'd1234, 8'd5},
        '{4'd0,  2'd1, 3'd2, 12'd100,  12'd4, 12'd106,  8'd3},
        '{4'd15, 2'd2, 3'd1, 12'd2000, 12'd3, 12'd2001, 8'd3},
        '{4'd7,  2'd3, 3'd3, 12'd10,   12'd1, 12'd13,   8'd7}
    };

    typedef struct packed {
        logic [1:0]  mode;
        logic [11:0] val;
        logic        hit;
    } rvec_t;

    localparam rvec_t RVECS[6] = '{
        '{2'd1, 12'd1500, 1'b1},
        '{2'd0, 12'd1500, 1'b0},
        '{2'd0, 12'd500,  1'b1},
        '{2'd2, 12'd2500, 1'b1},
        '{2'd3, 12'd1500, 1'b0},
        '{2'd3, 12'd2500, 1'b1}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk({busy, conv_start, res_valid, irq, evt_status} == 7'd0, "R9 reset outputs",
            int'({busy, conv_start, res_valid, irq, evt_status}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9 idle after reset", int'(busy), 0);

        // vector table: single-slot scans (R2, R3)
        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            cfg_ch_en = '0; cfg_ch_en[v.ch] = 1'b1;
            cfg_acq_sel = '0; cfg_acq_sel[int'(v.ch)*2 +: 2] = v.sel;
            cfg_avg_en = '0; cfg_avg_en[v.ch] = (v.lg != 0);
            cfg_avg_log2 = v.lg;
            conv_base = v.base; conv_step = v.step;
            run_scan(0);
            chk(first_lat == int'(v.lat), "R2 acquisition latency", first_lat, int'(v.lat));
            chk(n_conv == (1 << v.lg), "R3 conversion count", n_conv, 1 << v.lg);
            chk(n_res == 1 && r_val[0] == int'(v.exp_val), "R3 averaged value", r_val[0], int'(v.exp_val));
            chk(r_ch[0] == int'(v.ch), "R1 channel tag", r_ch[0], int'(v.ch));
        end
        clear_all();

        // R1 ascending order, R3 averaging disabled ignores log2
        cfg_ch_en = 16'h8421; cfg_avg_en = '0; cfg_avg_log2 = 3'd3; cfg_acq_sel = '0;
        conv_base = 12'd50; conv_step = 12'd1;
        run_scan(0);
        chk(n_res == 4, "R1 result count", n_res, 4);
        for (int i = 0; i < 4; i++) begin
            chk(r_ch[i] == i * 5, "R1 ascending slot", r_ch[i], i * 5);
            chk(r_val[i] == 50 + i, "R3 unaveraged value", r_val[i], 50 + i);
        end
        chk(n_conv == 4, "R3 one conversion per slot", n_conv, 4);
        clear_all();

        // R4 saturation on raw sample, averaged result 4094
        cfg_ch_en = 16'h0004; cfg_avg_en = 16'h0004; cfg_avg_log2 = 3'd1;
        cfg_sat_en = 16'h0004; conv_base = 12'd4095; conv_step = 12'hFFE;
        run_scan(0);
        chk(r_val[0] == 4094, "R4 mean value", r_val[0], 4094);
        chk(evt_status[1] == 1'b1, "R4 saturation set", int'(evt_status[1]), 1);
        clear_all();
        cfg_sat_en = '0;
        run_scan(0);
        chk(evt_status[1] == 1'b0, "R4 saturation disabled", int'(evt_status[1]), 0);
        cfg_sat_en = 16'h0004; cfg_avg_en = '0; conv_base = 12'd0; conv_step = 12'd0;
        run_scan(0);
        chk(evt_status[1] == 1'b1, "R4 zero sample", int'(evt_status[1]), 1);
        cfg_sat_en = '0;
        clear_all();

        // R5 range codes
        cfg_ch_en = 16'h0002; cfg_rng_en = 16'h0002; cfg_avg_en = '0;
        foreach (RVECS[i]) begin
            cfg_rng_mode = RVECS[i].mode; conv_base = RVECS[i].val; conv_step = '0;
            run_scan(0);
            chk(evt_status[2] == RVECS[i].hit, "R5 range condition",
                int'(evt_status[2]), int'(RVECS[i].hit));
            clear_all();
        end
        cfg_rng_en = '0; cfg_rng_mode = 2'd1; conv_base = 12'd1500;
        run_scan(0);
        chk(evt_status[2] == 1'b0, "R5 range disabled", int'(evt_status[2]), 0);
        clear_all();

        // R6 deferred end-of-scan
        cfg_ch_en = 16'h0010; cfg_scan_cnt = 4'd3; conv_base = 12'd7; conv_step = 12'd1;
        run_scan(0);
        chk(n_res == 3, "R6 three scans", n_res, 3);
        chk(r_val[2] == 9, "R6 third value", r_val[2], 9);
        chk(r_eos[2] == 1'b0, "R6 no early end-of-scan", int'(r_eos[2]), 0);
        @(negedge clk);
        chk(evt_status[0] == 1'b1, "R6 end-of-scan after burst", int'(evt_status[0]), 1);

        // R8 mask and write-1 clear
        evt_mask = 3'b110;
        @(negedge clk);
        chk(irq == 1'b0, "R8 masked irq", int'(irq), 0);
        evt_mask = 3'b001;
        @(negedge clk);
        chk(irq == 1'b1, "R8 unmasked irq", int'(irq), 1);
        @(negedge clk); evt_clear = 3'b110;
        @(negedge clk); evt_clear = 3'b000;
        chk(evt_status == 3'b001, "R8 clear other bits keeps", int'(evt_status), 1);
        clear_all();
        chk(evt_status == 3'b000 && irq == 1'b0, "R8 cleared", int'(evt_status), 0);
        cfg_scan_cnt = '0;

        // R7 restart while busy
        cfg_ch_en = 16'h0001; cfg_avg_en = 16'h0001; cfg_avg_log2 = 3'd2;
        cfg_acq_sel = 32'h3; conv_base = 12'd20; conv_step = 12'd0;
        run_scan(6);
        chk(n_res == 1, "R7 single result", n_res, 1);
        repeat (10) @(negedge clk);
        chk(busy == 1'b0 && n_conv == 4, "R7 no restart", n_conv, 4);
        clear_all();

        // R11 empty scan
        cfg_ch_en = '0;
        run_scan(0);
        @(negedge clk);
        chk(n_res == 0 && n_conv == 0, "R11 no activity", n_res + n_conv, 0);
        chk(evt_status[0] == 1'b1, "R11 end-of-scan", int'(evt_status[0]), 1);

        // R10 request discipline over whole run
        chk(conv_viol == 0, "R10 single request", conv_viol, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule